// File: doc/BRIEF.md
# DDR2 Mode Register Load Sequencer

This block writes the two configuration registers of a DDR2 memory device through its command pins. Software supplies the individual fields: CAS latency, a DLL reset request, the DLL control bit, output drive strength, a two-bit termination select and additive latency. The block packs these fields into a mode register word and an extended mode register word on the row address bus. It drives the bank address to select the target register and issues load commands on CS#, RAS#, CAS# and WE#.

A power-up trigger runs the whole sequence with no dummy accesses. The extended mode register is loaded first, and the mode register follows after a parameterized gap (`WAIT_CYC`, the minimum load-to-load spacing). A second trigger loads only the mode register. NOP commands fill every gap cycle, including the cycle right after each load. Once the trailing gap has elapsed, a sticky done flag rises and the pins return to deselect.

Top module: `ddr2_mrs_seq`

## Requirements
- R1: Out of reset, the pins show deselect ({cs_no,ras_no,cas_no,we_no} = 4'b1111), ba_o = 0, addr_o = 0, busy_o = 0 and done_o = 0.
- R2: A mode register load drives ba_o = 2'b00. addr_o[6:4] carries cas_lat_i and addr_o[8] carries dll_rst_i. Every other address bit, including bit 7 and bits 13:9, is 0.
- R3: An extended mode register load drives ba_o = 2'b01. The address bits are: bit 0 = dll_ctl_i, bit 1 = ods_i, bit 2 = rtt_i[0], bit 6 = rtt_i[1], bits 5:3 = additive latency. All other address bits are 0.
- R4: An additive latency input above 5 is loaded as 5. Values 0 to 5 pass unchanged.
- R5: A load command is {cs_no,ras_no,cas_no,we_no} = 4'b0000. The power-up trigger, sampled at a clock edge while idle, gives the extended load in the cycle after that edge. The mode register load follows exactly WAIT_CYC cycles later.
- R6: The cycle after each load, and every cycle up to the next load or the end of the run, shows NOP (4'b0111) with ba_o and addr_o at 0.
- R7: The mode-register-only trigger, sampled while idle, gives one mode register load in the next cycle and no extended load.
- R8: busy_o is high from the first load cycle until the last NOP. In the cycle WAIT_CYC after the final load, busy_o falls and done_o rises. done_o stays high until the next accepted trigger clears it in that trigger's first load cycle.
- R9: Triggers sampled while busy have no effect. If both triggers arrive together while idle, the power-up sequence runs.
- R10: After the final NOP, the pins return to deselect with ba_o and addr_o at 0 and stay there while no trigger is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrup_go_i | input | 1 | Start the full power-up load sequence |
| mr_go_i | input | 1 | Start a mode-register-only load |
| cas_lat_i | input | 3 | CAS latency field |
| dll_rst_i | input | 1 | DLL reset request placed in the mode register |
| dll_ctl_i | input | 1 | DLL control bit of the extended register |
| ods_i | input | 1 | Output drive strength select |
| rtt_i | input | 2 | Termination value select |
| add_lat_i | input | 3 | Additive latency, clamped to 5 |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address / register select |
| addr_o | output | ROW_W | Row address bus carrying the register word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed (sticky) |

## Verification
The hardest case to reach from the ports is a trigger that lands mid-run. Such a trigger must neither restart the counter nor add a load in the gap between the two loads or in the trailing gap. The bench holds both triggers high from the second cycle of a power-up run through the last busy edge. It checks every cycle against the undisturbed timeline and then confirms that the pins stay at deselect. A separate run raises both triggers together to confirm that the extended load goes first.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;
  typedef enum logic [1:0] {CMD_DESEL, CMD_NOP, CMD_LOAD} cmd_e;

  localparam logic [3:0] PINS_DESEL = 4'b1111;
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_LOAD  = 4'b0000;

  localparam logic [1:0] BA_MR  = 2'b00;
  localparam logic [1:0] BA_EMR = 2'b01;

  localparam logic [2:0] AL_MAX = 3'd5;
endpackage

// File: rtl/ddr2_mr_words.sv
module ddr2_mr_words
  import ddr2_mrs_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic [2:0]       cas_lat_i,
  input  logic             dll_rst_i,
  input  logic             dll_ctl_i,
  input  logic             ods_i,
  input  logic [1:0]       rtt_i,
  input  logic [2:0]       add_lat_i,
  output logic [ROW_W-1:0] mr_word_o,
  output logic [ROW_W-1:0] emr_word_o
);
  logic [2:0] al_clamped;

  assign al_clamped = (add_lat_i > AL_MAX) ? AL_MAX : add_lat_i;

  always_comb begin
    mr_word_o      = '0;
    mr_word_o[6:4] = cas_lat_i;
    mr_word_o[8]   = dll_rst_i;
  end

  always_comb begin
    emr_word_o      = '0;
    emr_word_o[0]   = dll_ctl_i;
    emr_word_o[1]   = ods_i;
    emr_word_o[2]   = rtt_i[0];
    emr_word_o[5:3] = al_clamped;
    emr_word_o[6]   = rtt_i[1];
  end
endmodule

// File: rtl/ddr2_mrs_ctrl.sv
module ddr2_mrs_ctrl
  import ddr2_mrs_pkg::*;
#(
  parameter int WAIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrup_go_i,
  input  logic mr_go_i,
  output cmd_e cmd_o,
  output logic sel_emr_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  typedef enum logic {ST_IDLE, ST_GAP} state_e;

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             done_q, done_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    done_d    = done_q;
    cmd_o     = CMD_DESEL;
    sel_emr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pwrup_go_i || mr_go_i) begin
          cmd_o     = CMD_LOAD;
          sel_emr_o = pwrup_go_i;  // power-up wins, extended register first
          pend_d    = pwrup_go_i;
          cnt_d     = CNT_LOAD;
          done_d    = 1'b0;
          state_d   = ST_GAP;
        end
      end
      ST_GAP: begin
        cmd_o = CMD_NOP;
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (pend_q) begin
          cmd_o  = CMD_LOAD;
          pend_d = 1'b0;
          cnt_d  = CNT_LOAD;
        end else begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_GAP);
  assign done_o = done_q;

  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == ST_IDLE);

  assert_busy_ignores_go_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && !pend_q && cnt_q != '0) |=> state_q == ST_GAP && !pend_q);
endmodule

// File: rtl/ddr2_cmd_out.sv
module ddr2_cmd_out
  import ddr2_mrs_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int WAIT_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic             sel_emr_i,
  input  logic [ROW_W-1:0] mr_word_i,
  input  logic [ROW_W-1:0] emr_word_i,
  output logic [3:0]       pins_o,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int SINCE_W = $clog2(WAIT_CYC + 1);

  logic [3:0]       pins_q;
  logic [1:0]       ba_q;
  logic [ROW_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= PINS_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          pins_q <= PINS_LOAD;
          ba_q   <= sel_emr_i ? BA_EMR : BA_MR;
          addr_q <= sel_emr_i ? emr_word_i : mr_word_i;
        end
        CMD_NOP: begin
          pins_q <= PINS_NOP;
          ba_q   <= '0;
          addr_q <= '0;
        end
        default: begin
          pins_q <= PINS_DESEL;
          ba_q   <= '0;
          addr_q <= '0;
        end
      endcase
    end
  end

  assign pins_o = pins_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;

  // spacing checker: cycles since the previous load, saturating
  logic               load_now;
  logic               seen_q;
  logic [SINCE_W-1:0] since_q;

  assign load_now = (pins_q == PINS_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      since_q <= '0;
    end else if (load_now) begin
      seen_q  <= 1'b1;
      since_q <= SINCE_W'(1);
    end else if (since_q < SINCE_W'(WAIT_CYC)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_load_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_now && seen_q) |-> since_q == SINCE_W'(WAIT_CYC));

  assert_nop_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_now |=> pins_q == PINS_NOP);

  assert_idle_bus_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_now |-> (addr_q == '0 && ba_q == '0));

  assert_mr_zero_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_now && ba_q == BA_MR) |-> (addr_q[7] == 1'b0 && addr_q[3:0] == '0 && addr_q[ROW_W-1:9] == '0));

  assert_al_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_now && ba_q == BA_EMR) |-> addr_q[5:3] <= AL_MAX);
endmodule

// File: rtl/ddr2_mrs_seq.sv
module ddr2_mrs_seq
  import ddr2_mrs_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int WAIT_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwrup_go_i,
  input  logic             mr_go_i,
  input  logic [2:0]       cas_lat_i,
  input  logic             dll_rst_i,
  input  logic             dll_ctl_i,
  input  logic             ods_i,
  input  logic [1:0]       rtt_i,
  input  logic [2:0]       add_lat_i,
  output logic             cs_no,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o,
  output logic             done_o
);
  cmd_e             cmd;
  logic             sel_emr;
  logic [ROW_W-1:0] mr_word;
  logic [ROW_W-1:0] emr_word;
  logic [3:0]       pins;

  ddr2_mr_words #(.ROW_W(ROW_W)) u_words (
    .cas_lat_i  (cas_lat_i),
    .dll_rst_i  (dll_rst_i),
    .dll_ctl_i  (dll_ctl_i),
    .ods_i      (ods_i),
    .rtt_i      (rtt_i),
    .add_lat_i  (add_lat_i),
    .mr_word_o  (mr_word),
    .emr_word_o (emr_word)
  );

  ddr2_mrs_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwrup_go_i (pwrup_go_i),
    .mr_go_i    (mr_go_i),
    .cmd_o      (cmd),
    .sel_emr_o  (sel_emr),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  ddr2_cmd_out #(.ROW_W(ROW_W), .WAIT_CYC(WAIT_CYC)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .sel_emr_i  (sel_emr),
    .mr_word_i  (mr_word),
    .emr_word_i (emr_word),
    .pins_o     (pins),
    .ba_o       (ba_o),
    .addr_o     (addr_o)
  );

  assign {cs_no, ras_no, cas_no, we_no} = pins;
endmodule

// File: tb/tb_ddr2_mrs_seq.sv
module tb_ddr2_mrs_seq;
  localparam int CLK_P    = 10;
  localparam int ROW_W    = 14;
  localparam int WAIT_CYC = 4;

  localparam logic [3:0] P_DESEL = 4'b1111;
  localparam logic [3:0] P_NOP   = 4'b0111;
  localparam logic [3:0] P_LOAD  = 4'b0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwrup_go = 1'b0, mr_go = 1'b0;
  logic [2:0] cas_lat = '0, add_lat = '0;
  logic dll_rst = 1'b0, dll_ctl = 1'b0, ods = 1'b0;
  logic [1:0] rtt = '0;
  logic cs_n, ras_n, cas_n, we_n, busy, done;
  logic [1:0] ba;
  logic [ROW_W-1:0] addr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr2_mrs_seq #(.ROW_W(ROW_W), .WAIT_CYC(WAIT_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwrup_go_i(pwrup_go), .mr_go_i(mr_go),
    .cas_lat_i(cas_lat), .dll_rst_i(dll_rst), .dll_ctl_i(dll_ctl), .ods_i(ods),
    .rtt_i(rtt), .add_lat_i(add_lat),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .addr_o(addr), .busy_o(busy), .done_o(done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_bus(string req, logic [3:0] p, logic [1:0] b, logic [ROW_W-1:0] a);
    chk(req, "pins", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, p});
    chk(req, "ba", {30'd0, ba}, {30'd0, b});
    chk(req, "addr", 32'(addr), 32'(a));
  endtask

  function automatic logic [ROW_W-1:0] exp_mr(logic [2:0] cl, logic dr);
    logic [ROW_W-1:0] w = '0;
    w[6:4] = cl;
    w[8]   = dr;
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] exp_emr(logic dc, logic od, logic [1:0] rt, logic [2:0] al);
    logic [ROW_W-1:0] w = '0;
    w[0]   = dc;
    w[1]   = od;
    w[2]   = rt[0];
    w[6]   = rt[1];
    w[5:3] = (al > 3'd5) ? 3'd5 : al;
    return w;
  endfunction

  task automatic set_fields(logic [2:0] cl, logic dr, logic dc, logic od, logic [1:0] rt, logic [2:0] al);
    @(negedge clk);
    cas_lat = cl; dll_rst = dr; dll_ctl = dc; ods = od; rtt = rt; add_lat = al;
  endtask

  // full power-up run; noise holds both triggers high while busy, both raises mr_go at start
  task automatic run_pwrup(string tag, logic noise, logic both);
    logic [ROW_W-1:0] e_emr = exp_emr(dll_ctl, ods, rtt, add_lat);
    logic [ROW_W-1:0] e_mr  = exp_mr(cas_lat, dll_rst);
    string rq;
    @(negedge clk);
    pwrup_go = 1'b1; mr_go = both;
    @(negedge clk);
    pwrup_go = 1'b0; mr_go = 1'b0;
    for (int off = 0; off <= 2*WAIT_CYC + 3; off++) begin
      rq = noise ? "R9" : tag;
      if (off == 0)                 chk_bus(noise ? "R9" : "R3", P_LOAD, 2'b01, e_emr);
      else if (off == WAIT_CYC)     chk_bus(noise ? "R9" : "R5", P_LOAD, 2'b00, e_mr);
      else if (off <= 2*WAIT_CYC)   chk_bus(noise ? "R9" : "R6", P_NOP, 2'b00, '0);
      else                          chk_bus(noise ? "R9" : "R10", P_DESEL, 2'b00, '0);
      chk(noise ? rq : "R8", "busy", 32'(busy), 32'(off < 2*WAIT_CYC));
      chk(noise ? rq : "R8", "done", 32'(done), 32'(off >= 2*WAIT_CYC));
      if (noise) begin
        pwrup_go = (off >= 1 && off <= 2*WAIT_CYC - 2);
        mr_go    = (off >= 1 && off <= 2*WAIT_CYC - 2);
      end
      @(negedge clk);
    end
    pwrup_go = 1'b0; mr_go = 1'b0;
  endtask

  task automatic run_mr_only();
    logic [ROW_W-1:0] e_mr = exp_mr(cas_lat, dll_rst);
    @(negedge clk);
    mr_go = 1'b1;
    @(negedge clk);
    mr_go = 1'b0;
    for (int off = 0; off <= WAIT_CYC + 2; off++) begin
      if (off == 0)             chk_bus("R7", P_LOAD, 2'b00, e_mr);
      else if (off <= WAIT_CYC) chk_bus("R7", P_NOP, 2'b00, '0);
      else                      chk_bus("R10", P_DESEL, 2'b00, '0);
      chk("R8", "busy", 32'(busy), 32'(off < WAIT_CYC));
      chk("R8", "done", 32'(done), 32'(off >= WAIT_CYC));
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk_bus("R1", P_DESEL, 2'b00, '0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
  endtask

  task automatic test_clamp();
    for (int al = 0; al < 8; al++) begin
      set_fields(3'd4, 1'b0, 1'b1, 1'b1, 2'b11, 3'(al));
      run_pwrup("R4", 1'b0, 1'b0);
      chk("R4", "clamp_ref", 32'(exp_emr(1'b0, 1'b0, 2'b00, 3'(al)) >> 3), (al > 5) ? 32'd5 : 32'(al));
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();

    set_fields(3'd3, 1'b1, 1'b1, 1'b0, 2'b01, 3'd2);
    run_pwrup("R5", 1'b0, 1'b0);
    set_fields(3'd5, 1'b0, 1'b0, 1'b1, 2'b10, 3'd7);
    run_pwrup("R2", 1'b0, 1'b0);
    set_fields(3'd6, 1'b1, 1'b1, 1'b1, 2'b00, 3'd6);
    run_mr_only();
    set_fields(3'd2, 1'b0, 1'b1, 1'b0, 2'b11, 3'd1);
    run_pwrup("R9", 1'b1, 1'b0);
    set_fields(3'd7, 1'b1, 1'b0, 1'b0, 2'b01, 3'd5);
    run_pwrup("R9", 1'b0, 1'b1);
    test_clamp();

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_bus("R10", P_DESEL, 2'b00, '0);
      chk("R8", "done_sticky", 32'(done), 32'd1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule